// File: doc/BRIEF.md
# Receive Character Buffer with Overflow Holding Slot

This block is the receive-side store of one serial channel. Whole characters come in from a deserializer or a loopback path, one per cycle with a valid strobe. They are queued in a small first-in first-out store, and a host drains them through a read strobe. When the store is full, one more character can wait in a single holding slot. A character that arrives while that slot is already occupied replaces the waiting one and raises an overrun flag. When the host reads, the waiting character moves into the store, so arrival order is kept.

The block also keeps the receive-related bits of the channel status byte and drives a receiver-ready line for an interrupt controller. The host controls the receiver with enable, disable, receiver-reset and error-clear strobes. The two transmitter bits of the status byte come in on ports and are passed through unchanged.

If several events fall in the same cycle, they take effect in a fixed order: the host read first, then the arriving character (accepted only if the receiver was enabled before that cycle), then the control strobes. A receiver reset overrides everything else.

Top module: `rxq_buffer`

## Requirements
- R1: After reset the status byte is 0x00, `rd_data` is 0 and the receiver is disabled.
- R2: The store holds DEPTH (3) characters, and reads return them oldest first. `rd_data` gives the returned character combinationally in the cycle `rd_en` is high, and the store advances at the next clock edge.
- R3: Status bit 1 (store full) is set when a stored arrival fills the store. A read clears it unless the holding slot refills the store.
- R4: An arrival that finds the store full goes to the holding slot. The next read returns the oldest stored character and moves the held character into the store, so bit 1 stays set.
- R5: An arrival while the holding slot is still occupied replaces the held character and sets status bit 4 (overrun). Reads do not clear bit 4.
- R6: Status bit 0 (receiver ready, also on `rx_ready`) is set by every accepted arrival. It is cleared by a read that leaves the store empty.
- R7: A read while the receiver is disabled or the store is empty returns 0 and changes no state.
- R8: The enable and disable strobes each clear bit 0. Disable wins if both are raised. Arrivals while the receiver is disabled are dropped, and stored characters survive a disable and re-enable.
- R9: A receiver reset disables the receiver, empties the store and the holding slot, and clears bits 0 and 1.
- R10: Per-character parity, framing and break flags set status bits 5, 6 and 7. A successful read clears bits 5 and 7 and leaves bits 4 and 6 unchanged.
- R11: The error-clear strobe clears status bits 4 to 7.
- R12: Status bits 2 and 3 copy `tx_ready` and `tx_empty`.
- R13: When a read and an arrival fall in the same cycle, the read is applied first. An arrival that finds the holding slot freed by that read's refill is held without overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Arriving character strobe |
| in_data | input | 8 | Arriving character |
| in_perr | input | 1 | Parity error flag of the arriving character |
| in_ferr | input | 1 | Framing error flag of the arriving character |
| in_brk | input | 1 | Break flag of the arriving character |
| rd_en | input | 1 | Host read strobe |
| rd_data | output | 8 | Character returned by the read in this cycle, 0 if none |
| cmd_enable | input | 1 | Enable receiver |
| cmd_disable | input | 1 | Disable receiver |
| cmd_reset | input | 1 | Receiver reset |
| cmd_err_clr | input | 1 | Clear error bits |
| tx_ready | input | 1 | Transmitter ready, copied to status bit 2 |
| tx_empty | input | 1 | Transmitter empty, copied to status bit 3 |
| status | output | 8 | Channel status byte |
| rx_ready | output | 1 | Receiver ready, for interrupts |

## Verification
A wrong count or pointer in the store shows on `rd_data` at the first read after the fault: a character is repeated, skipped or returned out of order. A lost or stale holding slot shows on the fourth read after a fill. It can also show as a wrong overrun bit right after the fifth arrival. Flag faults show on `status` one clock after the arrival, read or strobe that should have changed them. The sweeps therefore compare the status byte after every step and the read value in every read cycle.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int CHAR_W = 8;

    localparam int SB_RDY  = 0;
    localparam int SB_FULL = 1;
    localparam int SB_TXR  = 2;
    localparam int SB_TXE  = 3;
    localparam int SB_OVR  = 4;
    localparam int SB_PAR  = 5;
    localparam int SB_FRM  = 6;
    localparam int SB_BRK  = 7;

    typedef struct packed {
        logic              en;
        logic              rdy;
        logic              full;
        logic              ovr;
        logic              par;
        logic              frm;
        logic              brk;
        logic              hold_v;
        logic [CHAR_W-1:0] hold;
    } rx_ctrl_t;
endpackage

// File: rtl/rxq_slots.sv
module rxq_slots #(
    parameter int DEPTH = 3,
    parameter int W     = 8,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    input  logic          clear,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           rp;
        logic [PW-1:0]           wp;
        logic [CW-1:0]           cnt;
    } slots_t;

    slots_t st_d, st_q;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.rp  = '0;
            st_d.wp  = '0;
            st_d.cnt = '0;
        end else begin
            if (pop) st_d.rp = nxt(st_q.rp);
            if (push) begin
                st_d.mem[st_q.wp] = push_data;
                st_d.wp = nxt(st_q.wp);
            end
            st_d.cnt = st_q.cnt - CW'(pop) + CW'(push);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head  = st_q.mem[st_q.rp];
    assign count = st_q.cnt;

    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH));
    a_r2_push_needs_room: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !clear && st_q.cnt == CW'(DEPTH)) |-> pop);
    a_r2_pop_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !clear) |-> (st_q.cnt != '0));
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
    import rxq_pkg::*;
#(
    parameter int DEPTH = 3,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [CHAR_W-1:0] in_data,
    input  logic              in_perr,
    input  logic              in_ferr,
    input  logic              in_brk,
    input  logic              rd_en,
    input  logic              cmd_enable,
    input  logic              cmd_disable,
    input  logic              cmd_reset,
    input  logic              cmd_err_clr,
    input  logic [CW-1:0]     fifo_cnt,
    input  logic [CHAR_W-1:0] fifo_head,
    output logic              push,
    output logic [CHAR_W-1:0] push_data,
    output logic              pop,
    output logic              clear,
    output logic [CHAR_W-1:0] rd_data,
    output logic [7:0]        rx_bits
);
    rx_ctrl_t st_d, st_q;

    logic do_read, refill, accept, to_fifo;
    int   c_after_read, c_after_refill, c_final;

    always_comb begin
        st_d = st_q;

        do_read = rd_en && st_q.en && (fifo_cnt != '0);
        refill  = do_read && st_q.hold_v;
        accept  = in_valid && st_q.en;

        c_after_read   = int'(fifo_cnt) - (do_read ? 1 : 0);
        c_after_refill = c_after_read + (refill ? 1 : 0);
        to_fifo        = accept && (c_after_refill < DEPTH);
        c_final        = c_after_refill + (to_fifo ? 1 : 0);

        // host read step
        if (do_read) begin
            st_d.full = 1'b0;
            st_d.par  = 1'b0;
            st_d.brk  = 1'b0;
        end
        if (refill) begin
            st_d.hold_v = 1'b0;
            if (c_after_refill == DEPTH) st_d.full = 1'b1;
        end
        if (do_read && c_final == 0) st_d.rdy = 1'b0;

        // arrival step
        if (accept) begin
            st_d.rdy = 1'b1;
            if (in_perr) st_d.par = 1'b1;
            if (in_ferr) st_d.frm = 1'b1;
            if (in_brk)  st_d.brk = 1'b1;
            if (to_fifo) begin
                if (c_final == DEPTH) st_d.full = 1'b1;
            end else begin
                if (st_q.hold_v && !refill) st_d.ovr = 1'b1;
                st_d.hold_v = 1'b1;
                st_d.hold   = in_data;
            end
        end

        // control step
        if (cmd_disable) begin
            st_d.en  = 1'b0;
            st_d.rdy = 1'b0;
        end else if (cmd_enable) begin
            st_d.en  = 1'b1;
            st_d.rdy = 1'b0;
        end
        if (cmd_err_clr) begin
            st_d.ovr = 1'b0;
            st_d.par = 1'b0;
            st_d.frm = 1'b0;
            st_d.brk = 1'b0;
        end
        if (cmd_reset) begin
            st_d.en     = 1'b0;
            st_d.rdy    = 1'b0;
            st_d.full   = 1'b0;
            st_d.hold_v = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pop       = do_read;
    assign push      = refill || to_fifo;
    assign push_data = refill ? st_q.hold : in_data;
    assign clear     = cmd_reset;
    assign rd_data   = do_read ? fifo_head : '0;

    always_comb begin
        rx_bits          = '0;
        rx_bits[SB_RDY]  = st_q.rdy;
        rx_bits[SB_FULL] = st_q.full;
        rx_bits[SB_OVR]  = st_q.ovr;
        rx_bits[SB_PAR]  = st_q.par;
        rx_bits[SB_FRM]  = st_q.frm;
        rx_bits[SB_BRK]  = st_q.brk;
    end

    // R4: a held character only exists while the store is full
    a_r4_hold_implies_full: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.hold_v |-> (fifo_cnt == CW'(DEPTH)));
    // R3: the full flag tracks the store occupancy
    a_r3_full_flag_matches: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.full == (fifo_cnt == CW'(DEPTH)));
    // R5: overrun survives reads
    a_r5_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ovr && !cmd_err_clr) |=> st_q.ovr);
    // R7: a disabled receiver does not move the store
    a_r7_disabled_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.en && !cmd_reset) |=> $stable(fifo_cnt));
    // R7: empty read returns zero
    a_r7_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && fifo_cnt == '0) |-> (rd_data == '0));
    // R9: reset empties the store
    a_r9_reset_empties: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reset |=> (fifo_cnt == '0 && !st_q.hold_v && !st_q.en));
endmodule

// File: rtl/rxq_buffer.sv
module rxq_buffer
    import rxq_pkg::*;
#(
    parameter int DEPTH = 3,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    input  logic        in_perr,
    input  logic        in_ferr,
    input  logic        in_brk,
    input  logic        rd_en,
    output logic [7:0]  rd_data,
    input  logic        cmd_enable,
    input  logic        cmd_disable,
    input  logic        cmd_reset,
    input  logic        cmd_err_clr,
    input  logic        tx_ready,
    input  logic        tx_empty,
    output logic [7:0]  status,
    output logic        rx_ready
);
    logic              push, pop, clear;
    logic [CHAR_W-1:0] push_data, head;
    logic [CW-1:0]     cnt;
    logic [7:0]        rx_bits;

    rxq_slots #(.DEPTH(DEPTH), .W(CHAR_W)) u_slots (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
        .pop(pop), .clear(clear), .head(head), .count(cnt)
    );

    rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_perr(in_perr), .in_ferr(in_ferr), .in_brk(in_brk), .rd_en(rd_en),
        .cmd_enable(cmd_enable), .cmd_disable(cmd_disable),
        .cmd_reset(cmd_reset), .cmd_err_clr(cmd_err_clr),
        .fifo_cnt(cnt), .fifo_head(head), .push(push), .push_data(push_data),
        .pop(pop), .clear(clear), .rd_data(rd_data), .rx_bits(rx_bits)
    );

    always_comb begin
        status         = rx_bits;
        status[SB_TXR] = tx_ready;
        status[SB_TXE] = tx_empty;
    end
    assign rx_ready = rx_bits[SB_RDY];

    // R6/R12: port-level consistency of the status byte
    a_r6_ready_mirrors: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready == status[SB_RDY]);
    a_r12_tx_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (status[SB_TXR] == tx_ready) && (status[SB_TXE] == tx_empty));
endmodule

// File: tb/sim_rxq_buffer.sv
module sim_rxq_buffer;
    localparam int CLK_P = 10;

    logic clk = 0, rst_n = 0;
    logic in_valid = 0, in_perr = 0, in_ferr = 0, in_brk = 0, rd_en = 0;
    logic [7:0] in_data = 0;
    logic cmd_enable = 0, cmd_disable = 0, cmd_reset = 0, cmd_err_clr = 0;
    logic tx_ready = 0, tx_empty = 0;
    logic [7:0] rd_data, status;
    logic rx_ready;

    int checks = 0, errors = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    rxq_buffer u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_perr(in_perr), .in_ferr(in_ferr), .in_brk(in_brk), .rd_en(rd_en),
        .rd_data(rd_data), .cmd_enable(cmd_enable), .cmd_disable(cmd_disable),
        .cmd_reset(cmd_reset), .cmd_err_clr(cmd_err_clr), .tx_ready(tx_ready),
        .tx_empty(tx_empty), .status(status), .rx_ready(rx_ready)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // advance one clock, then drop all strobes
    task automatic cyc();
        @(posedge clk); #1;
        in_valid = 0; in_perr = 0; in_ferr = 0; in_brk = 0; rd_en = 0;
        cmd_enable = 0; cmd_disable = 0; cmd_reset = 0; cmd_err_clr = 0;
    endtask

    task automatic put(input logic [7:0] d);
        in_valid = 1; in_data = d; cyc();
    endtask

    task automatic get(input logic [7:0] exp, input string req);
        rd_en = 1; #1; chk(rd_data, exp, req); cyc();
    endtask

    task automatic fresh();
        cmd_reset = 1; cyc(); cmd_enable = 1; cyc();
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        chk(status, 8'h00, "R1 status after reset");
        rd_en = 1; #1; chk(rd_data, 8'h00, "R1 rd_data after reset"); cyc();

        // R8: arrival while disabled is dropped
        put(8'h55);
        chk(status, 8'h00, "R8 disabled drop status");
        cmd_enable = 1; cyc();
        get(8'h00, "R8 dropped char not stored");
        chk(status, 8'h00, "R7 empty read changes nothing");

        // Sweep of arrival counts: R2 R3 R4 R5 R6
        for (int n = 1; n <= 6; n++) begin
            logic [7:0] exp_st;
            fresh();
            for (int i = 0; i < n; i++) put(8'(16*n + i + 1));
            exp_st = 8'h01 | ((n >= 3) ? 8'h02 : 8'h00) | ((n >= 5) ? 8'h10 : 8'h00);
            chk(status, exp_st, "R3 R5 R6 status after fill");
            for (int k = 0; k < 5; k++) begin
                logic [7:0] e;
                if (k < 3 && k < n)      e = 8'(16*n + k + 1);
                else if (k == 3 && n > 3) e = 8'(16*n + n);
                else                      e = 8'h00;
                get(e, "R2 R4 read order");
                if (k == 0)
                    chk({7'd0, status[1]}, {7'd0, n > 3}, "R4 full kept by refill");
            end
            chk({7'd0, rx_ready}, 8'h00, "R6 ready clears when empty");
            chk({7'd0, status[4]}, {7'd0, n >= 5}, "R5 overrun survives reads");
            cmd_err_clr = 1; cyc();
            chk(status, 8'h00, "R11 error clear");
        end

        // R8: enable clears ready but keeps data; disable wins
        fresh();
        put(8'hA1);
        cmd_enable = 1; cyc();
        chk(status, 8'h00, "R8 enable clears ready");
        get(8'hA1, "R8 data survives enable");
        put(8'hA2);
        cmd_enable = 1; cmd_disable = 1; cyc();
        get(8'h00, "R8 disable wins, R7 disabled read zero");
        cmd_enable = 1; cyc();
        get(8'hA2, "R8 data survives disable");

        // R9: receiver reset
        fresh();
        for (int i = 0; i < 4; i++) put(8'(8'hB0 + i));
        cmd_reset = 1; cyc();
        chk(status, 8'h00, "R9 reset clears bits");
        get(8'h00, "R9 disabled after reset");
        cmd_enable = 1; cyc();
        get(8'h00, "R9 store emptied");

        // R10: error flags
        fresh();
        in_perr = 1; in_ferr = 1; in_brk = 1; put(8'hC1);
        chk(status, 8'hE1, "R10 flags set");
        get(8'hC1, "R10 read value");
        chk(status, 8'h40, "R10 read clears parity and break");
        cmd_err_clr = 1; cyc();
        chk(status, 8'h00, "R11 framing cleared");

        // R12: transmitter bits
        tx_ready = 1; #1; chk(status, 8'h04, "R12 tx ready bit");
        tx_ready = 0; tx_empty = 1; #1; chk(status, 8'h08, "R12 tx empty bit");
        tx_empty = 0; #1;

        // R13: simultaneous read and arrival
        fresh();
        put(8'hD1);
        rd_en = 1; in_valid = 1; in_data = 8'hD2; #1;
        chk(rd_data, 8'hD1, "R13 read first value"); cyc();
        chk(status, 8'h01, "R13 ready stays");
        get(8'hD2, "R13 arrival stored");
        fresh();
        for (int i = 0; i < 4; i++) put(8'(8'hE1 + i));
        rd_en = 1; in_valid = 1; in_data = 8'hE5; #1;
        chk(rd_data, 8'hE1, "R13 read with full hold"); cyc();
        chk(status, 8'h03, "R13 no overrun after refill");
        for (int i = 1; i < 5; i++) get(8'(8'hE1 + i), "R13 order after refill");
        chk(status, 8'h00, "R13 drained");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule